// File: doc/BRIEF.md
# Sector Erase Accumulation Window

This block gathers sector erase requests for a flash array into one batch before any erase begins. The first valid request opens a timed acceptance window and marks that sector in a mask. Every further valid request that arrives while the window is open adds its sector and restarts the window. When the window runs out with no new request, the block commits the batch. It raises a one-cycle erase-start pulse and holds the mask steady for the array erase engine until that engine reports completion.

The window status flag reads 0 while requests are still being collected and 1 once the erase has been committed. Busy rises as soon as the first request is taken, so the polling and toggle status logic can rely on it before the window closes. Any ordinary command written during the window cancels the batch. A suspend command written during the window leaves the batch alone. After commit, nothing written to the block has any effect until the erase-done input arrives.

Top module: `sector_erase_collector`

## Requirements
- R1: After synchronous reset, `sector_mask` is all zero and `busy`, `window_closed` and `erase_start` are 0.
- R2: In idle, a `se_req` whose `se_sector` is below `N_SECT` is accepted at that clock edge. From the next cycle `busy` is 1, `window_closed` is 0 and `sector_mask` has only bit `se_sector` set (bit i stands for sector i).
- R3: If no further request is accepted, `window_closed` rises exactly `WIN_CYC` cycles after the accepting edge. `erase_start` is 1 only in the first cycle in which `window_closed` is 1.
- R4: While the window is open, an in-range `se_req` ORs its sector bit into `sector_mask` and restarts the window. `window_closed` then rises `WIN_CYC` cycles after the last accepted request.
- R5: A `se_req` with `se_sector` >= `N_SECT` is ignored. In idle it does not open a window. While the window is open it neither changes the mask nor restarts the window.
- R6: While the window is open, `cmd_wr` with `cmd_suspend` = 0 and no `se_req` in the same cycle cancels the batch. From the next cycle the mask is zero, `busy` and `window_closed` are 0, and no `erase_start` follows.
- R7: While the window is open, `cmd_wr` with `cmd_suspend` = 1 has no effect on the mask or on when the window closes.
- R8: While `window_closed` is 1, `se_req` and `cmd_wr` are ignored: the mask stays unchanged and `window_closed` stays 1.
- R9: `erase_done` while `window_closed` is 1 clears the mask and drops `busy` and `window_closed` from the next cycle. `erase_done` in idle has no effect.
- R10: In idle, `cmd_wr` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| se_req | input | 1 | One-cycle pulse: a sector erase command sequence has completed |
| se_sector | input | IDX_W | Sector index that goes with `se_req` |
| cmd_wr | input | 1 | One-cycle pulse: some other command was written |
| cmd_suspend | input | 1 | Qualifies `cmd_wr` as an erase suspend command |
| erase_done | input | 1 | The array erase engine has finished |
| sector_mask | output | N_SECT | Sectors queued for erase, bit i = sector i |
| erase_start | output | 1 | One-cycle pulse when the batch is committed |
| window_closed | output | 1 | 0 while collecting or idle, 1 once the erase is committed |
| busy | output | 1 | 1 from the first accepted request until done or cancel |

## Verification
The bench builds the block with `N_SECT` = 12 and `WIN_CYC` = 8. With twelve sectors on a 4-bit index, the values 12 to 15 are out of range, so the rejection path in R5 can be driven from the ports. An eight-cycle window keeps each closing point a few cycles away. That is enough to tell a restarted window from one that kept its first deadline, and an ignored out-of-range request from one that wrongly reloaded the timer.

// File: rtl/sew_pkg.sv
`timescale 1ns/1ps
package sew_pkg;

    typedef enum logic [1:0] {
        SEW_IDLE   = 2'd0,
        SEW_OPEN   = 2'd1,
        SEW_COMMIT = 2'd2
    } sew_state_e;

    typedef struct packed {
        logic tmr_load;
        logic mask_set;
        logic mask_clr;
    } sew_act_t;

    function automatic logic is_collecting(input sew_state_e s);
        return s == SEW_OPEN;
    endfunction

endpackage

// File: rtl/sew_window_timer.sv
`timescale 1ns/1ps
module sew_window_timer #(
    parameter int WIN_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WIN_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= RELOAD); // R4

    AST_RELOAD_SEEN: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == RELOAD); // R4
endmodule

// File: rtl/sew_sector_mask.sv
`timescale 1ns/1ps
module sew_sector_mask #(
    parameter int N_SECT = 19,
    parameter int IDX_W  = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              clr,
    output logic [N_SECT-1:0] mask
);
    logic [N_SECT-1:0] dec;

    for (genvar g = 0; g < N_SECT; g++) begin : g_dec
        assign dec[g] = (set_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mask <= '0;
        end else if (set_en) begin
            mask <= mask | dec;
        end
    end

    AST_SET_ADDS_BIT: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr) |=> ((mask & $past(dec)) == $past(dec))); // R4

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> mask == '0); // R9
endmodule

// File: rtl/sew_ctrl.sv
`timescale 1ns/1ps
module sew_ctrl
    import sew_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       se_req,
    input  logic       se_ok,
    input  logic       cmd_wr,
    input  logic       cmd_suspend,
    input  logic       erase_done,
    input  logic       win_expired,
    output sew_act_t   act,
    output sew_state_e state,
    output logic       erase_start
);
    sew_state_e state_n;
    logic accept, abort_b, commit, finish;

    always_comb begin
        accept  = se_req && se_ok && (state != SEW_COMMIT);
        abort_b = is_collecting(state) && cmd_wr && !cmd_suspend && !se_req;
        commit  = is_collecting(state) && win_expired && !accept && !abort_b;
        finish  = (state == SEW_COMMIT) && erase_done;

        act.tmr_load = accept;
        act.mask_set = accept;
        act.mask_clr = abort_b || finish;

        state_n = state;
        unique case (state)
            SEW_IDLE:   if (accept) state_n = SEW_OPEN;
            SEW_OPEN: begin
                if (abort_b)     state_n = SEW_IDLE;
                else if (commit) state_n = SEW_COMMIT;
            end
            SEW_COMMIT: if (finish) state_n = SEW_IDLE;
            default:    state_n = SEW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEW_IDLE;
            erase_start <= 1'b0;
        end else begin
            state       <= state_n;
            erase_start <= commit;
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start); // R3

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort_b |=> state == SEW_IDLE); // R6

    AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == SEW_COMMIT && !erase_done) |=> state == SEW_COMMIT); // R8
endmodule

// File: rtl/sector_erase_collector.sv
`timescale 1ns/1ps
module sector_erase_collector
    import sew_pkg::*;
#(
    parameter int N_SECT  = 19,
    parameter int WIN_CYC = 2500,
    parameter int IDX_W   = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              se_req,
    input  logic [IDX_W-1:0]  se_sector,
    input  logic              cmd_wr,
    input  logic              cmd_suspend,
    input  logic              erase_done,
    output logic [N_SECT-1:0] sector_mask,
    output logic              erase_start,
    output logic              window_closed,
    output logic              busy
);
    localparam logic [IDX_W:0] SECT_LIM = N_SECT[IDX_W:0];

    sew_act_t   act;
    sew_state_e state;
    logic       se_ok;
    logic       expired;

    assign se_ok = ({1'b0, se_sector} < SECT_LIM);

    sew_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .se_req      (se_req),
        .se_ok       (se_ok),
        .cmd_wr      (cmd_wr),
        .cmd_suspend (cmd_suspend),
        .erase_done  (erase_done),
        .win_expired (expired),
        .act         (act),
        .state       (state),
        .erase_start (erase_start)
    );

    sew_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (act.tmr_load),
        .run     (is_collecting(state)),
        .expired (expired)
    );

    sew_sector_mask #(.N_SECT(N_SECT), .IDX_W(IDX_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_en  (act.mask_set),
        .set_idx (se_sector),
        .clr     (act.mask_clr),
        .mask    (sector_mask)
    );

    assign window_closed = (state == SEW_COMMIT);
    assign busy          = (state != SEW_IDLE);

    AST_CLOSED_BUSY: assert property (@(posedge clk) disable iff (rst)
        window_closed |-> busy); // R2

    AST_START_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> (window_closed && !$past(window_closed))); // R3

    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (window_closed && !erase_done) |=> $stable(sector_mask)); // R8

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sector_mask == '0); // R9

    AST_BAD_IDX_NO_OPEN: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(se_req && se_ok)) |=> !busy); // R5
endmodule

// File: tb/sector_erase_collector_tb.sv
`timescale 1ns/1ps
module sector_erase_collector_tb;
    localparam int N = 12;
    localparam int W = 8;
    localparam int IW = $clog2(N);

    typedef struct {
        int          due;
        logic [N-1:0] mask;
        logic        busy;
        logic        dq3;
        logic        start;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic se_req = 1'b0;
    logic [IW-1:0] se_sector = '0;
    logic cmd_wr = 1'b0;
    logic cmd_suspend = 1'b0;
    logic erase_done = 1'b0;
    logic [N-1:0] sector_mask;
    logic erase_start, window_closed, busy;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sector_erase_collector #(.N_SECT(N), .WIN_CYC(W)) u_dut (
        .clk(clk), .rst(rst), .se_req(se_req), .se_sector(se_sector),
        .cmd_wr(cmd_wr), .cmd_suspend(cmd_suspend), .erase_done(erase_done),
        .sector_mask(sector_mask), .erase_start(erase_start),
        .window_closed(window_closed), .busy(busy)
    );

    // monitor: pops expectations as their cycle comes up
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (e.due < cyc) begin
                n_bad++;
                $display("FAIL %s: missed check at cycle %0d (actual now %0d, expected %0d)",
                         e.tag, e.due, cyc, e.due);
            end else if (sector_mask !== e.mask || busy !== e.busy ||
                         window_closed !== e.dq3 || erase_start !== e.start) begin
                n_bad++;
                $display("FAIL %s @%0d: actual mask=%h busy=%b closed=%b start=%b expected mask=%h busy=%b closed=%b start=%b",
                         e.tag, cyc, sector_mask, busy, window_closed, erase_start,
                         e.mask, e.busy, e.dq3, e.start);
            end
        end
    end

    function automatic logic [N-1:0] bitm(input int i);
        logic [N-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic expect_at(input int d, input logic [N-1:0] m, input logic b,
                             input logic c, input logic s, input string t);
        exp_t e;
        e.due = cyc + d; e.mask = m; e.busy = b; e.dq3 = c; e.start = s; e.tag = t;
        q.push_back(e);
    endtask

    task automatic pulse(input logic se, input int idx, input logic wr,
                         input logic sp, input logic dn);
        se_req = se;
        se_sector = idx[IW-1:0];
        cmd_wr = wr;
        cmd_suspend = sp;
        erase_done = dn;
        @(negedge clk);
        se_req = 1'b0; cmd_wr = 1'b0; cmd_suspend = 1'b0; erase_done = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] m;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        expect_at(1, '0, 0, 0, 0, "R1 reset state");
        step(2);

        // R10: command write in idle
        expect_at(1, '0, 0, 0, 0, "R10 idle write");
        pulse(0, 0, 1, 0, 0);

        // R2/R3: single sector, window expiry
        expect_at(1, bitm(3), 1, 0, 0, "R2 first accept");
        pulse(1, 3, 0, 0, 0);
        expect_at(W-1, bitm(3), 1, 0, 0, "R3 still open");
        expect_at(W,   bitm(3), 1, 1, 1, "R3 commit pulse");
        expect_at(W+1, bitm(3), 1, 1, 0, "R3 pulse one cycle");
        step(W+1);

        // R8: writes ignored after commit
        expect_at(1, bitm(3), 1, 1, 0, "R8 sector erase ignored");
        pulse(1, 5, 1, 0, 0);
        expect_at(1, bitm(3), 1, 1, 0, "R8 command ignored");
        pulse(0, 0, 1, 0, 0);

        // R9: done clears; done in idle ignored
        expect_at(1, '0, 0, 0, 0, "R9 done clears");
        pulse(0, 0, 0, 0, 1);
        expect_at(1, '0, 0, 0, 0, "R9 done in idle");
        pulse(0, 0, 0, 0, 1);

        // R4: second sector restarts window
        expect_at(1, bitm(0), 1, 0, 0, "R4 first");
        pulse(1, 0, 0, 0, 0);
        step(3);
        m = bitm(0) | bitm(11);
        expect_at(1, m, 1, 0, 0, "R4 added sector");
        pulse(1, 11, 0, 0, 0);
        expect_at(W-1, m, 1, 0, 0, "R4 window restarted");
        expect_at(W,   m, 1, 1, 1, "R4 commit after restart");
        step(W);
        expect_at(1, '0, 0, 0, 0, "R9 done after R4");
        pulse(0, 0, 0, 0, 1);

        // R5: out-of-range index
        expect_at(1, '0, 0, 0, 0, "R5 bad index in idle");
        pulse(1, 13, 0, 0, 0);
        expect_at(1, bitm(2), 1, 0, 0, "R5 good accept");
        pulse(1, 2, 0, 0, 0);
        step(2);
        expect_at(1, bitm(2), 1, 0, 0, "R5 bad index while open");
        pulse(1, 12, 0, 0, 0);
        expect_at(W-4, bitm(2), 1, 0, 0, "R5 open before deadline");
        expect_at(W-3, bitm(2), 1, 1, 1, "R5 no restart");
        step(W-3);
        expect_at(1, '0, 0, 0, 0, "R9 done after R5");
        pulse(0, 0, 0, 0, 1);

        // R6: other command cancels
        expect_at(1, bitm(7), 1, 0, 0, "R6 accept");
        pulse(1, 7, 0, 0, 0);
        step(2);
        expect_at(1, '0, 0, 0, 0, "R6 cancel");
        pulse(0, 0, 1, 0, 0);
        expect_at(W+1, '0, 0, 0, 0, "R6 no late commit");
        step(W+1);

        // R7: suspend write has no effect
        expect_at(1, bitm(4), 1, 0, 0, "R7 accept");
        pulse(1, 4, 0, 0, 0);
        step(1);
        expect_at(1, bitm(4), 1, 0, 0, "R7 suspend kept batch");
        pulse(0, 0, 1, 1, 0);
        expect_at(W-3, bitm(4), 1, 0, 0, "R7 open");
        expect_at(W-2, bitm(4), 1, 1, 1, "R7 commit on time");
        step(W-2);
        expect_at(1, '0, 0, 0, 0, "R9 done after R7");
        pulse(0, 0, 0, 0, 1);

        step(3);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL queue: actual %0d pending, expected 0", q.size());
        end
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule